// File: doc/BRIEF.md
# Multi-Tap Camera Frame Timing Generator

This block produces the camera-side video stream of an area sensor. On every rising edge of the pixel clock it presents ten 8-bit pixels side by side on ten output lanes. A frame-valid flag and a line-valid flag frame the stream. A start pulse begins one frame. The area-of-interest settings then decide how many clocks the frame lasts and which pixels it carries: first column, column count, first row, row count and inter-line blanking. The column settings are used as whole groups of ten pixels.

The block reads pixel groups from a sensor-side source. While it requests data it drives a row address and a ten-pixel group address, and the source answers in the same cycle with ten 10-bit pixels. A 2-bit shift select picks which 8 of the 10 bits reach each lane. All settings are captured when a frame starts, so software may rewrite them while a frame is running.

The sequencer is a five-state machine:
- IDLE: waits for a start pulse and goes to LEAD when the captured width and height are both non-zero.
- LEAD: FVAL is high and LVAL is low. It lasts one clock plus one clock per skipped column group, then goes to LINE.
- LINE: one clock per pixel group. It goes to BLANK after a line that is not the last, and to TAIL after the last line.
- BLANK: the inter-line gap, then back to LINE.
- TAIL: one clock with FVAL high after the last line, then IDLE.

Top module: `mtap_frame_gen`

## Requirements
- R1: While reset is held, and while no frame is running, `fval_o`, `lval_o` and every bit of `data_o` are 0.
- R2: After a clock edge samples `start_i` high in IDLE, `fval_o` goes high on the next clock edge.
- R3: The first rise of `lval_o` in a frame comes exactly 1 + floor(col/10) clocks after `fval_o` rises. With a start column of 0 that is one clock later.
- R4: Each line holds `lval_o` high for floor(width/10) consecutive clocks, and a frame has exactly `aoi_height_i` lines. Lines fetch rows `aoi_row_i`, `aoi_row_i`+1, and so on in order. Within a line, group addresses run upward from floor(col/10).
- R5: On each LVAL-high clock, lane k (`data_o[8k+7:8k]`) carries pixel 10n+k+1 of the line, where n is the clock index within the line. That pixel comes from source lane k (`src_data_i[10k+9:10k]`) of the group fetched on the previous clock.
- R6: The shift select chooses the 8 bits sent for each pixel:
  - 0 sends raw[9:2].
  - 1 sends raw[8:1].
  - 2 sends raw[7:0], or 255 when raw[9] or raw[8] is set.
  - 3 behaves as 0.
- R7: Between two lines of a frame, `lval_o` is low for `blank_i` clocks while `fval_o` stays high. A `blank_i` value of 0 is treated as 1.
- R8: `lval_o` is only high while `fval_o` is high. `fval_o` falls exactly one clock after the last LVAL-high clock of the frame.
- R9: The start column and width are rounded down to a multiple of ten.
- R10: All settings and the shift select are sampled only in the clock that starts a frame. Changes to them, and further start pulses, during a frame do not affect that frame.
- R11: A start pulse whose rounded width is 0, or whose height is 0, starts no frame. `fval_o` stays low.
- R12: Every bit of `data_o` is 0 on clocks where `lval_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; everything changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-frame request, sampled in IDLE |
| aoi_col_i | input | 11 | First column of the area of interest |
| aoi_width_i | input | 11 | Column count of the area of interest |
| aoi_row_i | input | 11 | First row of the area of interest |
| aoi_height_i | input | 11 | Row count of the area of interest |
| blank_i | input | 8 | LVAL-low clocks between lines |
| shift_sel_i | input | 2 | Bit window select for the 8 transmitted bits |
| src_req_o | output | 1 | Source read request for one pixel group |
| src_row_o | output | 11 | Row address of the requested group |
| src_grp_o | output | 8 | Ten-pixel group address within the row |
| src_data_i | input | 100 | Ten 10-bit pixels; lane k in bits [10k+9:10k] |
| fval_o | output | 1 | Frame valid |
| lval_o | output | 1 | Line valid |
| data_o | output | 80 | Ten 8-bit pixel lanes; lane k in bits [8k+7:8k] |

## Verification
The embedded assertions check the framing on every clock:
- LVAL stays inside FVAL.
- FVAL never rises together with LVAL.
- FVAL falls only after a clock with LVAL low.
- Every line lasts exactly the captured group count.
- A source request is always followed by an LVAL-high clock.
- The lanes are zero whenever LVAL is low.

Only the bench's scenarios can show the rest:
- The exact lead-in length for a given start column.
- The row and group order and the lane-to-pixel mapping.
- The four shift encodings, including saturation.
- Rounding of the column settings.
- That mid-frame writes and start pulses are ignored, and that a degenerate area produces no frame.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LINE,
        ST_BLANK,
        ST_TAIL
    } seq_state_t;

    localparam logic [1:0] SH_HIGH = 2'd0;
    localparam logic [1:0] SH_MID  = 2'd1;
    localparam logic [1:0] SH_SAT  = 2'd2;

endpackage

// File: rtl/mtap_bit_select.sv
module mtap_bit_select
    import mtap_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [1:0]       shift_i,
    input  logic [IN_W-1:0]  pix_i,
    output logic [OUT_W-1:0] pix_o
);
    logic [OUT_W-1:0] win;

    always_comb begin
        unique case (shift_i)
            SH_MID:  win = pix_i[IN_W-2 -: OUT_W];
            SH_SAT:  win = (|pix_i[IN_W-1:OUT_W]) ? {OUT_W{1'b1}} : pix_i[OUT_W-1:0];
            default: win = pix_i[IN_W-1 -: OUT_W];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     pix_o <= '0;
        else if (cap_i) pix_o <= win;
        else            pix_o <= '0;
    end

endmodule

// File: rtl/mtap_seq.sv
module mtap_seq
    import mtap_pkg::*;
#(
    parameter int LANES    = 10,
    parameter int MAX_COLS = 1280,
    parameter int MAX_ROWS = 1024,
    parameter int BLANK_W  = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start_i,
    input  logic [$clog2(MAX_COLS+1)-1:0]           col_i,
    input  logic [$clog2(MAX_COLS+1)-1:0]           width_i,
    input  logic [$clog2(MAX_ROWS+1)-1:0]           row_i,
    input  logic [$clog2(MAX_ROWS+1)-1:0]           height_i,
    input  logic [BLANK_W-1:0]                      blank_i,
    input  logic [1:0]                              shift_i,
    output logic                                    line_act_o,
    output logic [$clog2(MAX_ROWS+1)-1:0]           row_addr_o,
    output logic [$clog2(MAX_COLS/LANES+1)-1:0]     grp_addr_o,
    output logic [1:0]                              shift_o,
    output logic                                    fval_o,
    output logic                                    lval_o
);
    localparam int COL_W = $clog2(MAX_COLS+1);
    localparam int ROW_W = $clog2(MAX_ROWS+1);
    localparam int GRP_W = $clog2(MAX_COLS/LANES+1);
    localparam int CNT_W = (GRP_W+1 > BLANK_W) ? GRP_W+1 : BLANK_W;

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [GRP_W-1:0]   grp_q, col_base_q, wid_q;
    logic [ROW_W-1:0]   row_idx_q, row_base_q, hgt_q;
    logic [BLANK_W-1:0] blk_q;
    logic [1:0]         shift_q;
    logic [GRP_W-1:0]   col_grp_n, wid_grp_n;
    logic               frame_go, last_row;

    always_comb begin
        col_grp_n = GRP_W'(col_i / COL_W'(LANES));
        wid_grp_n = GRP_W'(width_i / COL_W'(LANES));
        frame_go  = start_i && (wid_grp_n != '0) && (height_i != '0);
        last_row  = (row_idx_q == hgt_q - ROW_W'(1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_go)    state_d = ST_LEAD;
            ST_LEAD:  if (cnt_q == '0) state_d = ST_LINE;
            ST_LINE:  if (cnt_q == '0) state_d = last_row ? ST_TAIL : ST_BLANK;
            ST_BLANK: if (cnt_q == '0) state_d = ST_LINE;
            ST_TAIL:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            grp_q      <= '0;
            row_idx_q  <= '0;
            col_base_q <= '0;
            wid_q      <= '0;
            row_base_q <= '0;
            hgt_q      <= '0;
            blk_q      <= '0;
            shift_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (frame_go) begin
                    col_base_q <= col_grp_n;
                    wid_q      <= wid_grp_n;
                    row_base_q <= row_i;
                    hgt_q      <= height_i;
                    blk_q      <= (blank_i == '0) ? BLANK_W'(1) : blank_i;
                    shift_q    <= shift_i;
                    cnt_q      <= CNT_W'(col_grp_n);
                    row_idx_q  <= '0;
                end
                ST_LEAD, ST_BLANK: begin
                    if (cnt_q == '0) begin
                        cnt_q <= CNT_W'(wid_q) - CNT_W'(1);
                        grp_q <= '0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_LINE: begin
                    grp_q <= grp_q + GRP_W'(1);
                    if (cnt_q == '0) begin
                        cnt_q     <= CNT_W'(blk_q) - CNT_W'(1);
                        row_idx_q <= row_idx_q + ROW_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_TAIL: ;
                default: ;
            endcase
        end
    end

    // registered framing outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fval_o <= 1'b0;
            lval_o <= 1'b0;
        end else begin
            fval_o <= (state_q != ST_IDLE);
            lval_o <= (state_q == ST_LINE);
        end
    end

    assign line_act_o = (state_q == ST_LINE);
    assign row_addr_o = row_base_q + row_idx_q;
    assign grp_addr_o = col_base_q + grp_q;
    assign shift_o    = shift_q;

    // run-length counter for the line-length check
    logic [GRP_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (lval_o) run_q <= run_q + (GRP_W+1)'(1);
        else             run_q <= '0;
    end

    AST_LVAL_INSIDE_FVAL: assert property (@(posedge clk) disable iff (!rst_n)
        lval_o |-> fval_o);                                          // R8
    AST_FVAL_LEADS_LVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fval_o) |-> !lval_o);                                  // R3
    AST_FVAL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fval_o) |-> !$past(lval_o));                           // R8
    AST_LINE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lval_o) |-> (run_q == {1'b0, wid_q}));                 // R4

endmodule

// File: rtl/mtap_frame_gen.sv
module mtap_frame_gen
    import mtap_pkg::*;
#(
    parameter int LANES    = 10,
    parameter int IN_W     = 10,
    parameter int OUT_W    = 8,
    parameter int MAX_COLS = 1280,
    parameter int MAX_ROWS = 1024,
    parameter int BLANK_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [$clog2(MAX_COLS+1)-1:0]       aoi_col_i,
    input  logic [$clog2(MAX_COLS+1)-1:0]       aoi_width_i,
    input  logic [$clog2(MAX_ROWS+1)-1:0]       aoi_row_i,
    input  logic [$clog2(MAX_ROWS+1)-1:0]       aoi_height_i,
    input  logic [BLANK_W-1:0]                  blank_i,
    input  logic [1:0]                          shift_sel_i,
    output logic                                src_req_o,
    output logic [$clog2(MAX_ROWS+1)-1:0]       src_row_o,
    output logic [$clog2(MAX_COLS/LANES+1)-1:0] src_grp_o,
    input  logic [LANES*IN_W-1:0]               src_data_i,
    output logic                                fval_o,
    output logic                                lval_o,
    output logic [LANES*OUT_W-1:0]              data_o
);
    logic [1:0] shift_q;

    mtap_seq #(
        .LANES(LANES), .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .BLANK_W(BLANK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .col_i     (aoi_col_i),
        .width_i   (aoi_width_i),
        .row_i     (aoi_row_i),
        .height_i  (aoi_height_i),
        .blank_i   (blank_i),
        .shift_i   (shift_sel_i),
        .line_act_o(src_req_o),
        .row_addr_o(src_row_o),
        .grp_addr_o(src_grp_o),
        .shift_o   (shift_q),
        .fval_o    (fval_o),
        .lval_o    (lval_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        mtap_bit_select #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_i  (src_req_o),
            .shift_i(shift_q),
            .pix_i  (src_data_i[k*IN_W +: IN_W]),
            .pix_o  (data_o[k*OUT_W +: OUT_W])
        );
    end

    AST_DATA_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lval_o |-> (data_o == '0));                                 // R12
    AST_REQ_THEN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        src_req_o |=> lval_o);                                       // R4

endmodule

// File: tb/mtap_frame_gen_bench.sv
module mtap_frame_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [10:0] aoi_col_i, aoi_width_i, aoi_row_i, aoi_height_i;
    logic [7:0]  blank_i;
    logic [1:0]  shift_sel_i;
    logic        src_req_o;
    logic [10:0] src_row_o;
    logic [7:0]  src_grp_o;
    logic [99:0] src_data_i;
    logic        fval_o, lval_o;
    logic [79:0] data_o;

    int vectors = 0;
    int fails   = 0;
    int t       = 0;
    bit disturb = 1'b0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    mtap_frame_gen u_mtap_frame_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .aoi_col_i(aoi_col_i), .aoi_width_i(aoi_width_i),
        .aoi_row_i(aoi_row_i), .aoi_height_i(aoi_height_i),
        .blank_i(blank_i), .shift_sel_i(shift_sel_i),
        .src_req_o(src_req_o), .src_row_o(src_row_o), .src_grp_o(src_grp_o),
        .src_data_i(src_data_i), .fval_o(fval_o), .lval_o(lval_o), .data_o(data_o)
    );

    function automatic logic [9:0] pix_val(int row, int grp, int k);
        return 10'((row * 97 + grp * 41 + k * 53 + 7) & 1023);
    endfunction

    function automatic logic [7:0] exp8(logic [9:0] raw, int sh);
        if (sh == 1) return raw[8:1];
        if (sh == 2) return (raw[9] | raw[8]) ? 8'hFF : raw[7:0];
        return raw[9:2];
    endfunction

    function automatic logic [79:0] exp_line(int row, int grp, int sh);
        logic [79:0] v;
        for (int k = 0; k < 10; k++) v[k*8 +: 8] = exp8(pix_val(row, grp, k), sh);
        return v;
    endfunction

    // sensor source model: answers in the same cycle
    always_comb begin
        for (int k = 0; k < 10; k++)
            src_data_i[k*10 +: 10] = pix_val(int'(src_row_o), int'(src_grp_o), k);
    end

    task automatic chk(string tag, logic f, logic l, logic [79:0] d);
        vectors++;
        if (fval_o !== f || lval_o !== l || data_o !== d) begin
            fails++;
            $display("FAIL %s t=%0d: fval/lval/data actual %b/%b/%h expected %b/%b/%h",
                     tag, t, fval_o, lval_o, data_o, f, l, d);
        end
    endtask

    task automatic step(string tag, logic f, logic l, logic [79:0] d);
        @(negedge clk);
        t++;
        if (disturb && t == 2) begin
            start_i     = 1'b1;
            aoi_width_i = 11'd100;
            aoi_col_i   = 11'd50;
            aoi_height_i = 11'd7;
            shift_sel_i = 2'd2;
        end
        if (disturb && t == 3) start_i = 1'b0;
        chk(tag, f, l, d);
    endtask

    task automatic run_frame(int col, int wid, int row, int hgt, int blk, int sh);
        int cg = col / 10;
        int wg = wid / 10;
        int eb = (blk == 0) ? 1 : blk;
        int esh = (sh == 3) ? 0 : sh;
        aoi_col_i = 11'(col); aoi_width_i = 11'(wid);
        aoi_row_i = 11'(row); aoi_height_i = 11'(hgt);
        blank_i = 8'(blk); shift_sel_i = 2'(sh);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 0;
        chk("R2 pre-frame", 1'b0, 1'b0, '0);
        for (int i = 0; i < cg + 1; i++) step("R3 R9 lead", 1'b1, 1'b0, '0);
        for (int r = 0; r < hgt; r++) begin
            for (int g = 0; g < wg; g++)
                step("R4 R5 R6 line", 1'b1, 1'b1, exp_line(row + r, cg + g, esh));
            if (r < hgt - 1)
                for (int b = 0; b < eb; b++) step("R7 R12 blank", 1'b1, 1'b0, '0);
        end
        step("R8 tail", 1'b1, 1'b0, '0);
        step("R8 end", 1'b0, 1'b0, '0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; start_i = 1'b0;
        aoi_col_i = '0; aoi_width_i = 11'd40; aoi_row_i = '0; aoi_height_i = 11'd2;
        blank_i = 8'd1; shift_sel_i = '0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 idle", 1'b0, 1'b0, '0);
        end
    endtask

    task automatic test_no_frame(int wid, int hgt);
        aoi_col_i = '0; aoi_width_i = 11'(wid); aoi_row_i = '0;
        aoi_height_i = 11'(hgt); shift_sel_i = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R11 no frame", 1'b0, 1'b0, '0);
        end
    endtask

    task automatic test_disturb();
        disturb = 1'b1;
        run_frame(10, 30, 3, 3, 1, 0);   // R10 mid-frame writes and start ignored
        disturb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_frame(0, 40, 0, 3, 2, 0);        // R2 R3 R4 R5 R6 R7 R8
        run_frame(30, 20, 5, 2, 0, 1);       // R3 offset, R7 zero blank, R6 mid window
        run_frame(25, 37, 1, 2, 3, 2);       // R9 rounding, R6 saturation
        run_frame(0, 1280, 1020, 2, 1, 3);   // R4 full width, R6 code 3
        test_disturb();                      // R10
        test_no_frame(9, 4);                 // R11 width rounds to 0
        test_no_frame(40, 0);                // R11 height 0
        run_frame(0, 10, 7, 1, 5, 0);        // R4 single line, single group
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule